// File: doc/BRIEF.md
# Serial Multi-Pattern Waveform Store

This block keeps four transmit waveform patterns for a bank of pulser channels. Each pattern is a pair of registers. One register holds the step-by-step drive for the high-side switch and the other holds the drive for the low-side switch. A 2-bit address picks the pattern that is being written. A serial clock, an active-low chip-select and a data input then shift bits into that pattern. The serial output shows the bit leaving the end of the addressed chain, so several blocks can be cascaded.

A size input sets how wide every pattern register is. When it is high the registers are 32 steps wide; when it is low they are 16 steps wide. The high-side register of the addressed pattern feeds its low-side register, so the two form one chain. A rising edge on the trigger input latches the current address as the active pattern. The channel sequencers read that pattern from two parallel buses.

All inputs are sampled on the system clock `clk`. A shift step happens on the first `clk` edge after `sck` rises, and a trigger happens on the first `clk` edge after `trig` rises.

Top module: `wf_pattern_store`

## Requirements
- R1: A synchronous reset (`rst` high) clears every pattern register and sets the active selection to pattern 1. After reset, `act_hi`, `act_lo` and `sdo` all read zero.
- R2: The address encoding is the same for loading and for triggering: `addr` 00 selects pattern 1, 01 selects pattern 2, 10 selects pattern 3 and 11 selects pattern 4.
- R3: With `wide`=1 the addressed pattern is one 64-step chain, and bits are written least significant first. After 64 shifts of stream bits b0..b63, bit b(k) sits in low-side bit k and bit b(32+k) sits in high-side bit k, for k from 0 to 31. Bit b0 is then on `sdo`.
- R4: A shift step takes place once for each rising edge of `sck`. Holding `sck` high or lowering it shifts nothing.
- R5: While `cs_n` is high, no pattern register changes, even when `sck` toggles.
- R6: The registers of the patterns that are not addressed keep their contents while the addressed pattern is shifting.
- R7: `sdo` always shows bit 0 of the low-side register of the addressed pattern. With further shifts, the low-side contents leave on `sdo` one bit per shift, lowest bit first.
- R8: A rising edge on `trig` latches `addr` as the active pattern. After that, `act_hi` and `act_lo` show the high-side and low-side registers of the latched pattern. Holding `trig` high, or changing `addr` afterwards, leaves the selection as it is.
- R9: With `wide`=0 the chain is 32 steps: bit b(k) goes to low-side bit k and bit b(16+k) goes to high-side bit k, for k from 0 to 15. Register bits 31:16 keep their contents and read as zero on `act_hi` and `act_lo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial shift clock; one step per rising edge |
| cs_n | input | 1 | Active-low chip-select that enables shifting |
| sdi | input | 1 | Serial data in, least significant bit first |
| sdo | output | 1 | Last bit of the addressed chain |
| addr | input | 2 | Pattern address for loading and for trigger |
| wide | input | 1 | 1 selects 32-step registers, 0 selects 16-step registers |
| trig | input | 1 | A rising edge latches the active pattern |
| act_hi | output | 32 | High-side register of the active pattern |
| act_lo | output | 32 | Low-side register of the active pattern |

## Verification
The assertions check on every cycle that the register contents are frozen whenever chip-select is high or no serial edge arrives. They also check that non-addressed patterns never move and that `sdo` steps to the next low-side bit after each shift. Finally, they check that the active selection changes only on a trigger edge and always takes the address, and that the upper halves read zero in narrow mode. The bit ordering across the full 64-step and 32-step chains can only be shown by the bench's scenarios. So can the fact that upper halves keep their contents through a narrow load, and the exact word that comes out serially. The bench loads known words and reads them back through the parallel view and the serial output.

// File: rtl/wf_pattern_pkg.sv
package wf_pattern_pkg;
  localparam int WF_STEPS_DEF = 32;
  localparam int WF_SLOTS_DEF = 4;
endpackage

// File: rtl/wf_edge_rise.sv
module wf_edge_rise (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/wf_pattern_slot.sv
module wf_pattern_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wide,
  input  logic         din,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int H = W / 2;

  // One shift step of a register: the new bit enters at the top of the
  // active width; bits above the active width keep their value.
  function automatic logic [W-1:0] push(input logic [W-1:0] v,
                                        input logic b, input logic full);
    logic [W-1:0] r;
    if (full) r = {b, v[W-1:1]};
    else      r = {v[W-1:H], b, v[H-1:1]};
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (step) begin
      hi <= push(hi, din, wide);
      lo <= push(lo, hi[0], wide);
    end
  end
endmodule

// File: rtl/wf_view_sel.sv
module wf_view_sel #(
  parameter int W  = 32,
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic [N-1:0][W-1:0] hi_all,
  input  logic [N-1:0][W-1:0] lo_all,
  input  logic [AW-1:0]       sel,
  input  logic                wide,
  output logic [W-1:0]        hi_out,
  output logic [W-1:0]        lo_out
);
  localparam int H = W / 2;

  function automatic logic [W-1:0] width_mask(input logic full);
    return full ? {W{1'b1}} : {{(W-H){1'b0}}, {H{1'b1}}};
  endfunction

  always_comb begin
    hi_out = hi_all[sel] & width_mask(wide);
    lo_out = lo_all[sel] & width_mask(wide);
  end
endmodule

// File: rtl/wf_pattern_store.sv
module wf_pattern_store #(
  parameter int W = wf_pattern_pkg::WF_STEPS_DEF,
  parameter int N = wf_pattern_pkg::WF_SLOTS_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck,
  input  logic                 cs_n,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic [$clog2(N)-1:0] addr,
  input  logic                 wide,
  input  logic                 trig,
  output logic [W-1:0]         act_hi,
  output logic [W-1:0]         act_lo
);
  localparam int AW = $clog2(N);

  logic                 sck_rise;
  logic                 trig_rise;
  logic [N-1:0]         slot_step;
  logic [N-1:0][W-1:0]  hi_q;
  logic [N-1:0][W-1:0]  lo_q;
  logic [AW-1:0]        act_sel;

  wf_edge_rise u_sck_edge  (.clk(clk), .rst(rst), .din(sck),  .rise(sck_rise));
  wf_edge_rise u_trig_edge (.clk(clk), .rst(rst), .din(trig), .rise(trig_rise));

  for (genvar p = 0; p < N; p++) begin : g_slot
    assign slot_step[p] = sck_rise & ~cs_n & (addr == AW'(p));
    wf_pattern_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst), .step(slot_step[p]), .wide(wide),
      .din(sdi), .hi(hi_q[p]), .lo(lo_q[p])
    );
  end

  assign sdo = lo_q[addr][0];

  always_ff @(posedge clk) begin
    if (rst)            act_sel <= '0;
    else if (trig_rise) act_sel <= addr;
  end

  wf_view_sel #(.W(W), .N(N), .AW(AW)) u_view (
    .hi_all(hi_q), .lo_all(lo_q), .sel(act_sel), .wide(wide),
    .hi_out(act_hi), .lo_out(act_lo)
  );
endmodule

// File: rtl/wf_pattern_store_chk.sv
module wf_pattern_store_chk #(
  parameter int W = 32,
  parameter int N = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic [$clog2(N)-1:0] addr,
  input logic                 wide,
  input logic                 sdo,
  input logic [W-1:0]         act_hi,
  input logic [W-1:0]         act_lo,
  input logic                 sck_rise,
  input logic                 trig_rise,
  input logic [$clog2(N)-1:0] act_sel,
  input logic [N-1:0][W-1:0]  hi_q,
  input logic [N-1:0][W-1:0]  lo_q
);
  localparam int AW = $clog2(N);
  localparam int H  = W / 2;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hi_q == '0) && (lo_q == '0) && (act_sel == '0));

  a_r4_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
    !sck_rise |=> $stable(hi_q) && $stable(lo_q));

  a_r5_cs_hold: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(hi_q) && $stable(lo_q));

  for (genvar p = 0; p < N; p++) begin : g_iso
    a_r6_other_slot_hold: assert property (@(posedge clk) disable iff (rst)
      (addr != AW'(p)) |=> $stable(hi_q[p]) && $stable(lo_q[p]));
  end

  a_r7_sdo_advance: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && !cs_n) |=>
      (addr != $past(addr)) || (sdo == $past(lo_q[addr][1])));

  a_r8_trig_latch: assert property (@(posedge clk) disable iff (rst)
    trig_rise |=> act_sel == $past(addr));

  a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !trig_rise |=> $stable(act_sel));

  a_r9_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !wide |-> (act_hi[W-1:H] == '0) && (act_lo[W-1:H] == '0));
endmodule

bind wf_pattern_store wf_pattern_store_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .wide(wide), .sdo(sdo),
  .act_hi(act_hi), .act_lo(act_lo), .sck_rise(sck_rise),
  .trig_rise(trig_rise), .act_sel(act_sel), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_wf_pattern_store.sv
module test_wf_pattern_store;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [1:0]  addr = 2'b00;
  logic        wide = 1'b1;
  logic        trig = 1'b0;
  logic [31:0] act_hi, act_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] LO_W = 32'hA5C3_1E77;
  localparam logic [31:0] HI_W = 32'h6B0F_D249;
  localparam logic [15:0] LO_N = 16'h9C2B;
  localparam logic [15:0] HI_N = 16'h47E1;

  always #4 clk = ~clk;

  wf_pattern_store i_wf_pattern_store (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .addr(addr), .wide(wide), .trig(trig), .act_hi(act_hi), .act_lo(act_lo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; sck = 1'b1; idle(2);
    sck = 1'b0; idle(2);
  endtask

  task automatic fire(input logic [1:0] a);
    addr = a; trig = 1'b1; idle(2);
    trig = 1'b0; idle(2);
  endtask

  task automatic t_reset();
    check("R1 act_hi", act_hi, 32'h0);
    check("R1 act_lo", act_lo, 32'h0);
    check("R1 sdo", {31'h0, sdo}, 32'h0);
  endtask

  task automatic t_wide_load();
    wide = 1'b1; addr = 2'b10; cs_n = 1'b0;
    for (int k = 0; k < 32; k++) shift_bit(LO_W[k]);
    for (int k = 0; k < 32; k++) shift_bit(HI_W[k]);
    cs_n = 1'b1;
    check("R3 sdo first bit", {31'h0, sdo}, {31'h0, LO_W[0]});
    fire(2'b10);
    check("R3 R2 act_lo pattern 3", act_lo, LO_W);
    check("R3 R2 act_hi pattern 3", act_hi, HI_W);
  endtask

  task automatic t_sdo_stream();
    logic [31:0] got;
    got = '0;
    addr = 2'b10; cs_n = 1'b0;
    for (int k = 0; k < 32; k++) begin
      got[k] = sdo;
      shift_bit(1'b0);
    end
    cs_n = 1'b1;
    check("R7 serial out word", got, LO_W);
    check("R7 sdo after stream", {31'h0, sdo}, {31'h0, HI_W[0]});
  endtask

  task automatic t_level_sck();
    addr = 2'b00; cs_n = 1'b0; sdi = 1'b1; sck = 1'b1;
    idle(2); sdi = 1'b0; idle(8);
    sck = 1'b0; idle(3);
    cs_n = 1'b1;
    fire(2'b00);
    check("R4 one step act_hi", act_hi, 32'h8000_0000);
    check("R4 one step act_lo", act_lo, 32'h0);
  endtask

  task automatic t_cs_hold();
    addr = 2'b00; cs_n = 1'b1;
    for (int k = 0; k < 5; k++) shift_bit(1'b1);
    check("R5 act_hi held", act_hi, 32'h8000_0000);
    check("R5 act_lo held", act_lo, 32'h0);
  endtask

  task automatic t_narrow();
    wide = 1'b1; addr = 2'b01; cs_n = 1'b0;
    for (int k = 0; k < 64; k++) shift_bit(1'b1);
    wide = 1'b0;
    for (int k = 0; k < 16; k++) shift_bit(LO_N[k]);
    for (int k = 0; k < 16; k++) shift_bit(HI_N[k]);
    cs_n = 1'b1;
    check("R9 sdo first bit", {31'h0, sdo}, {31'h0, LO_N[0]});
    fire(2'b01);
    check("R9 R2 narrow act_lo", act_lo, {16'h0, LO_N});
    check("R9 R2 narrow act_hi", act_hi, {16'h0, HI_N});
    wide = 1'b1; idle(1);
    check("R9 upper half kept lo", act_lo, {16'hFFFF, LO_N});
    check("R9 upper half kept hi", act_hi, {16'hFFFF, HI_N});
  endtask

  task automatic t_isolation();
    wide = 1'b1;
    fire(2'b10);
    check("R6 pattern 3 lo", act_lo, HI_W);
    check("R6 pattern 3 hi", act_hi, 32'h0);
    fire(2'b00);
    check("R6 pattern 1 hi", act_hi, 32'h8000_0000);
    fire(2'b11);
    check("R6 R2 pattern 4 untouched", act_hi | act_lo, 32'h0);
  endtask

  task automatic t_trig_hold();
    wide = 1'b1; addr = 2'b01; trig = 1'b1; idle(2);
    addr = 2'b11; idle(4);
    check("R8 trig held", act_hi, {16'hFFFF, HI_N});
    trig = 1'b0; idle(2);
    addr = 2'b10; idle(3);
    check("R8 addr change after", act_lo, {16'hFFFF, LO_N});
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_wide_load();
    t_sdo_stream();
    t_level_sck();
    t_cs_hold();
    t_narrow();
    t_isolation();
    t_trig_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule